// File: doc/BRIEF.md
# Multi-Child Linked-Structure Prefetch Lookup

This block sits on the demand path of a software-guided prefetcher for linked structures whose nodes carry several child pointers (trees, tries, multi-way lists). Software describes the structure once, outside its hot loops, through a small configuration write port. It gives the node size, a key offset, a list of child-pointer offsets added one at a time, and a few root address windows. A separate table builder fills a node table, which records known node base addresses, and a descendant chain table, which holds prefetch targets already linked in breadth-first order.

Each demand address is first tested against the root windows, and an address outside all of them does no lookup. Inside a window, the demand address minus the key offset is compared in parallel against every valid node table entry. An entry matches when the key falls within node-size bytes of its base. On a match, the block emits one prefetch per configured child offset relative to the matched base. It then walks the descendant chain from the entry's head and emits at most M further addresses. Prefetch addresses leave through a valid/ready handshake, and a matching entry has its recently-used bit set for the builder's replacement policy.

Top module: `multichild_prefetch`

## Requirements
- R1: After reset `pf_valid`, `offs_overflow` and every bit of `at_used` are 0, all root windows are empty, and no offsets are configured.
- R2: A demand whose address lies outside every root window [base, base+len) (unsigned, len 0 means empty) produces no prefetch and leaves `at_used` unchanged, even if a node entry would otherwise match.
- R3: Inside a root window, entry i matches when it is valid and (addr − key_offset − base_i) < node_size (unsigned); the lowest matching index wins, and the first prefetch is valid in the cycle after the demand is sampled.
- R4: On a match, the block emits base + offset_j for each configured child offset, in the order the offsets were added, before anything else.
- R5: After the children, if the matched entry has a descendant head, the block emits the chain entries' addresses from that head, following each entry's link. It stops after an entry marked last or after WALK_M addresses, whichever comes first.
- R6: A matching demand sets `at_used` bit of the matched index from the next cycle, and a builder write to an entry clears that entry's bit.
- R7: Configuration op codes on `cfg_op`: 0 node size, 1 append child offset, 2 clear offsets, 3 key offset, 4 root base (root `cfg_idx`), 5 root length (root `cfg_idx`). An append when MAX_OFFS offsets are already held is ignored and sets `offs_overflow`, and clear resets both the list and the flag.
- R8: While `pf_valid` is high and `pf_ready` low, `pf_addr` holds and `pf_valid` stays high. A new address is presented only after a transfer.
- R9: A matching demand during an ongoing walk abandons the old walk and restarts at the new node's first prefetch in the next cycle.
- R10: A non-matching demand during an ongoing walk leaves the walk's sequence of addresses unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_op | input | 3 | Configuration operation code (see R7) |
| cfg_idx | input | 2 | Root window index for ops 4 and 5 |
| cfg_wdata | input | 32 | Configuration write data |
| offs_overflow | output | 1 | Sticky flag: an offset append was dropped |
| at_we | input | 1 | Node table write strobe from the builder |
| at_widx | input | 8 | Node table write index |
| at_wvalid | input | 1 | Valid bit written to the entry |
| at_wbase | input | 32 | Node base address written to the entry |
| at_whead | input | 10 | Descendant chain head index for the entry |
| at_whas_desc | input | 1 | Entry has a descendant chain |
| cat_we | input | 1 | Descendant chain write strobe from the builder |
| cat_widx | input | 10 | Descendant chain write index |
| cat_waddr | input | 32 | Prefetch address stored in the chain entry |
| cat_wlink | input | 10 | Index of the next chain entry |
| cat_wlast | input | 1 | Chain entry ends its chain |
| dmd_valid | input | 1 | Demand access valid |
| dmd_addr | input | 32 | Demand access address |
| pf_valid | output | 1 | Prefetch request valid |
| pf_ready | input | 1 | Prefetch request accepted |
| pf_addr | output | 32 | Prefetch request address |
| at_used | output | 256 | Recently-used bits of the node table entries |

## Verification
The root test and the parallel match are combinational on the demand inputs and captured at the sampling edge. The first prefetch address is therefore due one cycle after the demand, and each later address is due one cycle after the transfer before it. `at_used` and `offs_overflow` reflect a hit or an append in the cycle after it. The bench drives every input on the falling edge and reads outputs on the next falling edge, so each demand's first prefetch is checked at exactly the second falling edge. Transfers are counted only at falling edges where both valid and ready are high, and a stall is checked by comparing the address at consecutive falling edges. Restart and miss-during-walk cases inject the second demand at the same falling edge as the first transfer, so the expected sequence is that first address followed by the new node's list.

// File: rtl/mcp_pkg.sv
package mcp_pkg;
    localparam int ADDR_W    = 32;
    localparam int AT_DEPTH  = 256;
    localparam int CAT_DEPTH = 1024;
    localparam int AT_IW     = $clog2(AT_DEPTH);
    localparam int CAT_IW    = $clog2(CAT_DEPTH);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [AT_IW-1:0]  at_idx_t;
    typedef logic [CAT_IW-1:0] cat_idx_t;

    typedef enum logic [2:0] {
        OP_NODE_SIZE     = 3'd0,
        OP_ADD_OFFSET    = 3'd1,
        OP_CLEAR_OFFSETS = 3'd2,
        OP_KEY_OFFSET    = 3'd3,
        OP_ROOT_BASE     = 3'd4,
        OP_ROOT_LEN      = 3'd5
    } cfg_op_e;

    typedef struct packed {
        addr_t    base;
        cat_idx_t head;
        logic     has_desc;
    } node_ent_t;

    typedef struct packed {
        addr_t    addr;
        cat_idx_t link;
        logic     last;
    } desc_ent_t;

    typedef struct packed {
        logic     hit;
        at_idx_t  idx;
        addr_t    base;
        cat_idx_t head;
        logic     has_desc;
    } hit_info_t;

    typedef enum logic [1:0] {
        W_IDLE,
        W_CHILD,
        W_DESC
    } walk_st_e;

    // Unsigned window test: a lies in [base, base + len)
    function automatic logic in_window(addr_t a, addr_t base, addr_t len);
        return (a - base) < len;
    endfunction
endpackage

// File: rtl/mcp_cfg.sv
module mcp_cfg
    import mcp_pkg::*;
#(
    parameter int MAX_OFFS  = 4,
    parameter int NUM_ROOTS = 4,
    localparam int OFF_CW  = $clog2(MAX_OFFS + 1),
    localparam int OFF_IW  = (MAX_OFFS > 1) ? $clog2(MAX_OFFS) : 1,
    localparam int ROOT_IW = (NUM_ROOTS > 1) ? $clog2(NUM_ROOTS) : 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cfg_we,
    input  logic [2:0]                   cfg_op,
    input  logic [ROOT_IW-1:0]           cfg_idx,
    input  addr_t                        cfg_wdata,
    output addr_t                        node_size,
    output addr_t                        key_off,
    output addr_t [MAX_OFFS-1:0]         offs,
    output logic  [OFF_CW-1:0]           n_offs,
    output logic                         offs_overflow,
    output addr_t [NUM_ROOTS-1:0]        root_base,
    output addr_t [NUM_ROOTS-1:0]        root_len
);
    always_ff @(posedge clk) begin
        if (rst) begin
            node_size     <= '0;
            key_off       <= '0;
            offs          <= '0;
            n_offs        <= '0;
            offs_overflow <= 1'b0;
            root_base     <= '0;
            root_len      <= '0;
        end else if (cfg_we) begin
            case (cfg_op)
                OP_NODE_SIZE:  node_size <= cfg_wdata;
                OP_KEY_OFFSET: key_off   <= cfg_wdata;
                OP_ADD_OFFSET: begin
                    if (n_offs < OFF_CW'(MAX_OFFS)) begin
                        offs[OFF_IW'(n_offs)] <= cfg_wdata;
                        n_offs                <= n_offs + OFF_CW'(1);
                    end else begin
                        offs_overflow <= 1'b1;
                    end
                end
                OP_CLEAR_OFFSETS: begin
                    offs          <= '0;
                    n_offs        <= '0;
                    offs_overflow <= 1'b0;
                end
                OP_ROOT_BASE: root_base[cfg_idx] <= cfg_wdata;
                OP_ROOT_LEN:  root_len[cfg_idx]  <= cfg_wdata;
                default: ;
            endcase
        end
    end

    // R7: a full offset list drops the append and raises the flag
    p_offset_limit_r7: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_op == OP_ADD_OFFSET && n_offs == OFF_CW'(MAX_OFFS))
        |=> (offs_overflow && $stable(n_offs) && $stable(offs)));
endmodule

// File: rtl/mcp_lookup.sv
module mcp_lookup
    import mcp_pkg::*;
#(
    parameter int NUM_ROOTS = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   dmd_valid,
    input  addr_t                  dmd_addr,
    input  addr_t                  node_size,
    input  addr_t                  key_off,
    input  addr_t [NUM_ROOTS-1:0]  root_base,
    input  addr_t [NUM_ROOTS-1:0]  root_len,
    input  logic                   at_we,
    input  at_idx_t                at_widx,
    input  logic                   at_wvalid,
    input  addr_t                  at_wbase,
    input  cat_idx_t               at_whead,
    input  logic                   at_whas_desc,
    output hit_info_t              hit,
    output logic [AT_DEPTH-1:0]    at_used
);
    logic [AT_DEPTH-1:0] at_vld;
    node_ent_t           at_tab [AT_DEPTH];
    logic [AT_DEPTH-1:0] match;
    logic                root_ok;
    addr_t               key;
    at_idx_t             win_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            at_vld <= '0;
        end else if (at_we) begin
            at_vld[at_widx] <= at_wvalid;
        end
    end

    always_ff @(posedge clk) begin
        if (at_we) begin
            at_tab[at_widx] <= '{base: at_wbase, head: at_whead, has_desc: at_whas_desc};
        end
    end

    // Base-and-bound filter over all root windows
    always_comb begin
        root_ok = 1'b0;
        for (int r = 0; r < NUM_ROOTS; r++) begin
            if (in_window(dmd_addr, root_base[r], root_len[r])) begin
                root_ok = 1'b1;
            end
        end
    end

    assign key = dmd_addr - key_off;

    // Parallel containment compare, one per entry
    for (genvar g = 0; g < AT_DEPTH; g++) begin : g_cmp
        assign match[g] = at_vld[g] && in_window(key, at_tab[g].base, node_size);
    end

    // Lowest matching index wins
    always_comb begin
        win_idx = '0;
        for (int i = AT_DEPTH - 1; i >= 0; i--) begin
            if (match[i]) begin
                win_idx = at_idx_t'(i);
            end
        end
    end

    always_comb begin
        hit.hit      = dmd_valid && root_ok && (|match);
        hit.idx      = win_idx;
        hit.base     = at_tab[win_idx].base;
        hit.head     = at_tab[win_idx].head;
        hit.has_desc = at_tab[win_idx].has_desc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            at_used <= '0;
        end else begin
            if (at_we) begin
                at_used[at_widx] <= 1'b0;
            end
            if (hit.hit) begin
                at_used[hit.idx] <= 1'b1;
            end
        end
    end

    // R2: a demand outside every root window touches no replacement state
    p_root_gate_r2: assert property (@(posedge clk) disable iff (rst)
        (dmd_valid && !root_ok && !at_we) |=> $stable(at_used));

    // R6: a hit marks its entry as recently used
    p_used_set_r6: assert property (@(posedge clk) disable iff (rst)
        hit.hit |=> at_used[$past(hit.idx)]);
endmodule

// File: rtl/mcp_walker.sv
module mcp_walker
    import mcp_pkg::*;
#(
    parameter int MAX_OFFS = 4,
    parameter int WALK_M   = 4,
    localparam int OFF_CW = $clog2(MAX_OFFS + 1),
    localparam int OFF_IW = (MAX_OFFS > 1) ? $clog2(MAX_OFFS) : 1,
    localparam int M_CW   = $clog2(WALK_M + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_hit,
    input  addr_t                 start_base,
    input  cat_idx_t              start_head,
    input  logic                  start_has_desc,
    input  addr_t [MAX_OFFS-1:0]  offs,
    input  logic  [OFF_CW-1:0]    n_offs,
    input  logic                  cat_we,
    input  cat_idx_t              cat_widx,
    input  addr_t                 cat_waddr,
    input  cat_idx_t              cat_wlink,
    input  logic                  cat_wlast,
    output logic                  pf_valid,
    input  logic                  pf_ready,
    output addr_t                 pf_addr
);
    desc_ent_t        cat_mem [CAT_DEPTH];
    walk_st_e         st;
    addr_t            node_base;
    logic             has_desc;
    logic [OFF_CW-1:0] k;
    logic [M_CW-1:0]  cnt;
    cat_idx_t         ptr;
    desc_ent_t        cur;
    logic             xfer;

    always_ff @(posedge clk) begin
        if (cat_we) begin
            cat_mem[cat_widx] <= '{addr: cat_waddr, link: cat_wlink, last: cat_wlast};
        end
    end

    assign cur      = cat_mem[ptr];
    assign pf_valid = (st != W_IDLE);
    assign xfer     = pf_valid && pf_ready;

    always_comb begin
        case (st)
            W_CHILD: pf_addr = node_base + offs[OFF_IW'(k)];
            W_DESC:  pf_addr = cur.addr;
            default: pf_addr = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= W_IDLE;
            node_base <= '0;
            has_desc  <= 1'b0;
            k         <= '0;
            cnt       <= '0;
            ptr       <= '0;
        end else if (start_hit) begin
            // A new hit always takes over, whatever the old walk was doing
            node_base <= start_base;
            has_desc  <= start_has_desc;
            k         <= '0;
            cnt       <= '0;
            ptr       <= start_head;
            if (n_offs != '0) begin
                st <= W_CHILD;
            end else if (start_has_desc) begin
                st <= W_DESC;
            end else begin
                st <= W_IDLE;
            end
        end else if (xfer) begin
            case (st)
                W_CHILD: begin
                    if (k + OFF_CW'(1) >= n_offs) begin
                        st <= has_desc ? W_DESC : W_IDLE;
                    end else begin
                        k <= k + OFF_CW'(1);
                    end
                end
                W_DESC: begin
                    if (cur.last || cnt == M_CW'(WALK_M - 1)) begin
                        st <= W_IDLE;
                    end else begin
                        ptr <= cur.link;
                        cnt <= cnt + M_CW'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // R8: a stalled request holds its address
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (pf_valid && !pf_ready && !start_hit && !cat_we) |=> (pf_valid && $stable(pf_addr)));

    // R5: the descendant walk never exceeds WALK_M addresses
    p_desc_bound_r5: assert property (@(posedge clk) disable iff (rst)
        (st == W_DESC) |-> (cnt < M_CW'(WALK_M)));

    // R9: a hit restarts at the new node's first child
    p_restart_r9: assert property (@(posedge clk) disable iff (rst)
        (start_hit && n_offs != '0) |=> (pf_valid && pf_addr == $past(start_base + offs[0])));
endmodule

// File: rtl/multichild_prefetch.sv
module multichild_prefetch
    import mcp_pkg::*;
#(
    parameter int MAX_OFFS  = 4,
    parameter int NUM_ROOTS = 4,
    parameter int WALK_M    = 4,
    localparam int OFF_CW  = $clog2(MAX_OFFS + 1),
    localparam int ROOT_IW = (NUM_ROOTS > 1) ? $clog2(NUM_ROOTS) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [2:0]            cfg_op,
    input  logic [ROOT_IW-1:0]    cfg_idx,
    input  logic [ADDR_W-1:0]     cfg_wdata,
    output logic                  offs_overflow,
    input  logic                  at_we,
    input  logic [AT_IW-1:0]      at_widx,
    input  logic                  at_wvalid,
    input  logic [ADDR_W-1:0]     at_wbase,
    input  logic [CAT_IW-1:0]     at_whead,
    input  logic                  at_whas_desc,
    input  logic                  cat_we,
    input  logic [CAT_IW-1:0]     cat_widx,
    input  logic [ADDR_W-1:0]     cat_waddr,
    input  logic [CAT_IW-1:0]     cat_wlink,
    input  logic                  cat_wlast,
    input  logic                  dmd_valid,
    input  logic [ADDR_W-1:0]     dmd_addr,
    output logic                  pf_valid,
    input  logic                  pf_ready,
    output logic [ADDR_W-1:0]     pf_addr,
    output logic [AT_DEPTH-1:0]   at_used
);
    addr_t                 node_size;
    addr_t                 key_off;
    addr_t [MAX_OFFS-1:0]  offs;
    logic  [OFF_CW-1:0]    n_offs;
    addr_t [NUM_ROOTS-1:0] root_base;
    addr_t [NUM_ROOTS-1:0] root_len;
    hit_info_t             hit;

    mcp_cfg #(.MAX_OFFS(MAX_OFFS), .NUM_ROOTS(NUM_ROOTS)) u_cfg (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_op(cfg_op), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .node_size(node_size), .key_off(key_off), .offs(offs), .n_offs(n_offs),
        .offs_overflow(offs_overflow), .root_base(root_base), .root_len(root_len)
    );

    mcp_lookup #(.NUM_ROOTS(NUM_ROOTS)) u_lookup (
        .clk(clk), .rst(rst),
        .dmd_valid(dmd_valid), .dmd_addr(dmd_addr),
        .node_size(node_size), .key_off(key_off),
        .root_base(root_base), .root_len(root_len),
        .at_we(at_we), .at_widx(at_widx), .at_wvalid(at_wvalid),
        .at_wbase(at_wbase), .at_whead(at_whead), .at_whas_desc(at_whas_desc),
        .hit(hit), .at_used(at_used)
    );

    mcp_walker #(.MAX_OFFS(MAX_OFFS), .WALK_M(WALK_M)) u_walker (
        .clk(clk), .rst(rst),
        .start_hit(hit.hit), .start_base(hit.base), .start_head(hit.head),
        .start_has_desc(hit.has_desc),
        .offs(offs), .n_offs(n_offs),
        .cat_we(cat_we), .cat_widx(cat_widx), .cat_waddr(cat_waddr),
        .cat_wlink(cat_wlink), .cat_wlast(cat_wlast),
        .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr)
    );
endmodule

// File: tb/multichild_prefetch_tb.sv
module multichild_prefetch_tb;
    import mcp_pkg::*;

    localparam int MAX_OFFS  = 4;
    localparam int NUM_ROOTS = 4;
    localparam int WALK_M    = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic                cfg_we = 0;
    logic [2:0]          cfg_op = 0;
    logic [1:0]          cfg_idx = 0;
    logic [31:0]         cfg_wdata = 0;
    logic                offs_overflow;
    logic                at_we = 0;
    logic [AT_IW-1:0]    at_widx = 0;
    logic                at_wvalid = 0;
    logic [31:0]         at_wbase = 0;
    logic [CAT_IW-1:0]   at_whead = 0;
    logic                at_whas_desc = 0;
    logic                cat_we = 0;
    logic [CAT_IW-1:0]   cat_widx = 0;
    logic [31:0]         cat_waddr = 0;
    logic [CAT_IW-1:0]   cat_wlink = 0;
    logic                cat_wlast = 0;
    logic                dmd_valid = 0;
    logic [31:0]         dmd_addr = 0;
    logic                pf_valid;
    logic                pf_ready = 0;
    logic [31:0]         pf_addr;
    logic [AT_DEPTH-1:0] at_used;

    multichild_prefetch #(.MAX_OFFS(MAX_OFFS), .NUM_ROOTS(NUM_ROOTS), .WALK_M(WALK_M)) u_dut (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_op(cfg_op), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .offs_overflow(offs_overflow),
        .at_we(at_we), .at_widx(at_widx), .at_wvalid(at_wvalid), .at_wbase(at_wbase),
        .at_whead(at_whead), .at_whas_desc(at_whas_desc),
        .cat_we(cat_we), .cat_widx(cat_widx), .cat_waddr(cat_waddr),
        .cat_wlink(cat_wlink), .cat_wlast(cat_wlast),
        .dmd_valid(dmd_valid), .dmd_addr(dmd_addr),
        .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr),
        .at_used(at_used)
    );

    int n_tests = 0;
    int n_fail  = 0;

    // Bench-side model of what has been configured and written
    logic [31:0] m_size = 0, m_key = 0;
    logic [31:0] m_offs[$];
    logic [31:0] m_rbase[NUM_ROOTS], m_rlen[NUM_ROOTS];
    bit          m_vld[AT_DEPTH];
    logic [31:0] m_base[AT_DEPTH];
    int          m_head[AT_DEPTH];
    bit          m_hd[AT_DEPTH];
    bit          m_used[AT_DEPTH];
    logic [31:0] c_addr[CAT_DEPTH];
    int          c_link[CAT_DEPTH];
    bit          c_last[CAT_DEPTH];
    logic [31:0] exp_q[$];
    logic [31:0] got[$];

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    function automatic int find_node(logic [31:0] a);
        bit inroot = 0;
        logic [31:0] key = a - m_key;
        for (int r = 0; r < NUM_ROOTS; r++)
            if ((a - m_rbase[r]) < m_rlen[r]) inroot = 1;
        if (!inroot) return -1;
        for (int i = 0; i < AT_DEPTH; i++)
            if (m_vld[i] && ((key - m_base[i]) < m_size)) return i;
        return -1;
    endfunction

    function automatic void add_exp(logic [31:0] a);
        int n = find_node(a);
        int p;
        if (n < 0) return;
        foreach (m_offs[j]) exp_q.push_back(m_base[n] + m_offs[j]);
        if (m_hd[n]) begin
            p = m_head[n];
            for (int c = 0; c < WALK_M; c++) begin
                exp_q.push_back(c_addr[p]);
                if (c_last[p]) break;
                p = c_link[p];
            end
        end
    endfunction

    task automatic cfg(logic [2:0] op, int idx, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_op = op; cfg_idx = idx[1:0]; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
        case (op)
            3'd0: m_size = d;
            3'd1: if (m_offs.size() < MAX_OFFS) m_offs.push_back(d);
            3'd2: m_offs.delete();
            3'd3: m_key = d;
            3'd4: m_rbase[idx] = d;
            3'd5: m_rlen[idx] = d;
            default: ;
        endcase
    endtask

    task automatic at_write(int idx, bit v, logic [31:0] b, int head, bit hd);
        @(negedge clk);
        at_we = 1; at_widx = AT_IW'(idx); at_wvalid = v; at_wbase = b;
        at_whead = CAT_IW'(head); at_whas_desc = hd;
        @(negedge clk);
        at_we = 0;
        m_vld[idx] = v; m_base[idx] = b; m_head[idx] = head; m_hd[idx] = hd; m_used[idx] = 0;
    endtask

    task automatic cat_write(int idx, logic [31:0] a, int link, bit last);
        @(negedge clk);
        cat_we = 1; cat_widx = CAT_IW'(idx); cat_waddr = a; cat_wlink = CAT_IW'(link); cat_wlast = last;
        @(negedge clk);
        cat_we = 0;
        c_addr[idx] = a; c_link[idx] = link; c_last[idx] = last;
    endtask

    // Collect transfers until the walk goes idle; also checks stall holding (R8)
    task automatic drain(int prob);
        bit          prev_stall = 0;
        logic [31:0] prev_a = 0;
        for (int c = 0; c < 400; c++) begin
            pf_ready = ($urandom_range(99) < prob);
            if (prev_stall)
                check(pf_valid && pf_addr == prev_a, "R8", "stalled request held", pf_addr, prev_a);
            if (!pf_valid) break;
            if (pf_ready) got.push_back(pf_addr);
            prev_stall = !pf_ready;
            prev_a     = pf_addr;
            @(negedge clk);
        end
        pf_ready = 0;
    endtask

    task automatic cmp_q(string req, string what);
        check(got.size() == exp_q.size(), req, {what, " count"}, got.size(), exp_q.size());
        if (got.size() == exp_q.size()) begin
            foreach (got[i]) begin
                if (got[i] !== exp_q[i]) begin
                    check(0, req, {what, " address"}, got[i], exp_q[i]);
                    break;
                end
            end
        end
    endtask

    task automatic check_used(string req);
        logic [AT_DEPTH-1:0] e;
        for (int i = 0; i < AT_DEPTH; i++) e[i] = m_used[i];
        check(at_used == e, req, "used bits", 64'(at_used[63:0]), 64'(e[63:0]));
    endtask

    task automatic demand(logic [31:0] a, int prob, string req);
        int n = find_node(a);
        exp_q.delete(); got.delete();
        add_exp(a);
        @(negedge clk);
        dmd_valid = 1; dmd_addr = a; pf_ready = 0;
        @(negedge clk);
        dmd_valid = 0;
        if (exp_q.size() > 0)
            check(pf_valid === 1'b1, "R3", "first prefetch one cycle after demand", pf_valid, 1);
        else
            check(pf_valid === 1'b0, req, "no prefetch expected", pf_valid, 0);
        drain(prob);
        if (n >= 0) m_used[n] = 1;
        cmp_q(req, "prefetch sequence");
    endtask

    // Second demand lands on the same edge as the first transfer of the first walk
    task automatic demand_pair(logic [31:0] a, logic [31:0] b, string req);
        logic [31:0] first;
        int na = find_node(a);
        int nb = find_node(b);
        exp_q.delete(); got.delete();
        add_exp(a);
        first = exp_q[0];
        @(negedge clk);
        dmd_valid = 1; dmd_addr = a; pf_ready = 0;
        @(negedge clk);
        dmd_addr = b; pf_ready = 1;
        check(pf_valid === 1'b1, req, "walk active at second demand", pf_valid, 1);
        got.push_back(pf_addr);
        if (nb >= 0) begin
            exp_q.delete();
            exp_q.push_back(first);
            add_exp(b);
        end
        @(negedge clk);
        dmd_valid = 0;
        drain(60);
        if (na >= 0) m_used[na] = 1;
        if (nb >= 0) m_used[nb] = 1;
        cmp_q(req, "sequence around second demand");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int r = 0; r < NUM_ROOTS; r++) begin m_rbase[r] = 0; m_rlen[r] = 0; end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1: reset state
        check(pf_valid === 1'b0, "R1", "pf_valid after reset", pf_valid, 0);
        check(offs_overflow === 1'b0, "R1", "overflow after reset", offs_overflow, 0);
        check_used("R1");

        // Configuration
        cfg(3'd0, 0, 32'd64);
        cfg(3'd3, 0, 32'd8);
        cfg(3'd4, 0, 32'h1000_0000);
        cfg(3'd5, 0, 32'h0010_0000);
        cfg(3'd4, 1, 32'h2000_0000);
        cfg(3'd5, 1, 32'h0000_1000);
        cfg(3'd1, 0, 32'h10);
        cfg(3'd1, 0, 32'h18);
        cfg(3'd1, 0, 32'h20);

        // Tables
        at_write(0, 1, 32'h1000_0100, 5, 1);
        at_write(1, 1, 32'h1000_0200, 0, 0);
        at_write(2, 1, 32'h2000_0040, 20, 1);
        at_write(3, 1, 32'h1000_0310, 0, 0);
        at_write(4, 1, 32'h3000_0000, 0, 0);
        at_write(5, 1, 32'h100F_FFC0, 0, 0);
        at_write(7, 1, 32'h1000_0300, 0, 0);
        for (int i = 5; i <= 10; i++) cat_write(i, 32'h5000_0000 + i * 32'h100, i + 1, 0);
        cat_write(20, 32'h6000_0000, 21, 0);
        cat_write(21, 32'h6000_1000, 0, 1);

        // R4/R5: children then chain truncated at WALK_M
        demand(32'h1000_010C, 100, "R4/R5 children then bounded chain");
        check_used("R6");
        demand(32'h1000_0247, 100, "R3 last byte inside node");
        demand(32'h1000_0248, 100, "R3 one past node end");
        demand(32'h1000_0320, 70, "R3 lowest index wins on overlap");
        demand(32'h1000_030D, 70, "R3 single overlap match");
        demand(32'h2000_004A, 30, "R5 chain ends at last entry");
        check_used("R6");

        // R2: root filtering
        demand(32'h3000_0008, 100, "R2 outside all roots");
        demand(32'h100F_FFFF, 100, "R2 last address inside root");
        demand(32'h1010_0000, 100, "R2 first address past root");
        check_used("R2");

        // R6: builder write clears used bit
        at_write(0, 1, 32'h1000_0100, 5, 1);
        check_used("R6");

        // R9 / R10
        demand_pair(32'h1000_010C, 32'h2000_004A, "R9 restart on new hit");
        demand_pair(32'h1000_010C, 32'h1000_0248, "R10 miss inside root during walk");
        demand_pair(32'h2000_004A, 32'h3000_0008, "R10 root miss during walk");
        check_used("R6");

        // R7: offset limit, overflow flag, clear
        cfg(3'd1, 0, 32'h28);
        @(negedge clk);
        check(offs_overflow === 1'b0, "R7", "flag at exactly MAX offsets", offs_overflow, 0);
        cfg(3'd1, 0, 32'h30);
        check(offs_overflow === 1'b1, "R7", "flag after dropped append", offs_overflow, 1);
        demand(32'h1000_0208, 100, "R7 only MAX offsets used");
        cfg(3'd2, 0, 0);
        check(offs_overflow === 1'b0, "R7", "flag after clear", offs_overflow, 0);
        demand(32'h2000_0048, 100, "R5 no offsets goes straight to chain");
        demand(32'h1000_0208, 100, "R4 no offsets no chain gives nothing");
        cfg(3'd1, 0, 32'h8);
        cfg(3'd1, 0, 32'h30);

        // Random phase
        for (int i = 100; i < 164; i++)
            cat_write(i, $urandom(), 100 + $urandom_range(63), ($urandom_range(3) == 0));
        for (int i = 16; i < 48; i++)
            at_write(i, 1, 32'h1000_0000 + i * 32'h400 + $urandom_range(15) * 64,
                     100 + $urandom_range(63), $urandom_range(1));
        for (int t = 0; t < 40; t++) begin
            logic [31:0] a;
            if ($urandom_range(4) == 0) a = 32'h1000_0000 + $urandom_range(32'h1FFFF);
            else a = m_base[16 + $urandom_range(31)] + 8 + $urandom_range(63);
            demand(a, 20 + $urandom_range(80), "R3/R4/R5 random demand");
        end
        check_used("R6");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule